// File: doc/BRIEF.md
# Serial Receive Path with Line Error Detection

This block takes an asynchronous serial line, oversamples it with a clock-enable pulse at sixteen times the bit rate, and rebuilds characters in a programmable format: one start bit, five to eight data bits, an optional even or odd parity bit, and one or two stop bits. Each good character goes into a 64-entry first-in-first-out store that a consumer drains through a show-ahead read port.

Line faults are reported as sticky flags: parity mismatch, bad stop bit, a character lost because the store was full, and a line held low for a whole frame (a break). A read strobe on the status clears them. When characters sit in the store and nothing new arrives for three word times, a time-out output is raised so the consumer can collect a short tail of data. For hardware flow control an active-low ready-to-receive output follows the free space in the store, with a hold band at the half-full point.

Top module: `sio_rx_core`

## Requirements
- R1: `fmt_dsel` selects the data width (0=5, 1=6, 2=7, 3=8 bits); data bits arrive least significant first and `rd_data` holds them right aligned with unused upper bits at zero.
- R2: Characters leave the store in arrival order; `rd_data` shows the oldest entry while `rx_empty` is low, a `rd_en` pulse removes it, and `rx_count` holds the number stored (at most 64).
- R3: A low level on `rxd` that is gone by the eighth tick after it was first seen is ignored: no character is stored and no flag is set.
- R4: With `fmt_par_en` high a parity bit follows the data; `fmt_par_odd`=0 expects an even count of ones over data and parity, 1 an odd count. A mismatch sets `err_parity` and the character is still stored.
- R5: A stop bit sampled low (the first, or the second when `fmt_two_stop` is high) in a frame holding at least one 1 sets `err_frame`; the character is still stored.
- R6: A frame whose start, data, parity and first stop samples are all low sets `err_break` only, stores nothing, and the receiver waits for `rxd` to return high before it accepts a new start bit.
- R7: A character completing while 64 entries are held sets `err_overrun`, is discarded, and leaves the stored entries unchanged.
- R8: The four error flags stay set until an `err_rd` pulse clears them.
- R9: `rx_timeout` rises after 48 ticks per frame bit (three word times of the current format) pass with the store not empty and no new character; a new character or an empty store drops it.
- R10: With `afc_en` high, `rts_n` goes low when more than 32 entries are free, high when fewer than 32 are free, and holds at exactly 32; with `afc_en` low it stays high.
- R11: After reset the store is empty, all flags and `rx_timeout` are low, and `rts_n` is low when `afc_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| fmt_dsel | input | 2 | Data width select, 0..3 for 5..8 bits |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1 odd parity, 0 even parity |
| fmt_two_stop | input | 1 | Two stop bits |
| afc_en | input | 1 | Drive `rts_n` from store free space |
| rd_en | input | 1 | Remove the oldest stored character |
| rd_data | output | 8 | Oldest stored character |
| rx_empty | output | 1 | Store holds nothing |
| rx_count | output | 7 | Number of stored characters |
| err_rd | input | 1 | Status read, clears the error flags |
| err_overrun | output | 1 | Character lost to a full store |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Line low for a full frame |
| rx_timeout | output | 1 | Stored data idle for three word times |
| rts_n | output | 1 | Active-low ready to receive |

## Verification
Frames are driven in several formats (8N1, five-bit, seven-bit with even and odd parity, two stop bits) so a wrong width select, bit order or alignment shows as a wrong byte. Single faults are injected one at a time, a flipped parity bit, a low first or second stop bit, a short low glitch and a long all-low break, to tell each flag apart from its neighbours and to confirm which faults still store the byte. A run of 65 back-to-back characters fills the store past its limit, crossing the half-full band of `rts_n` on the way, and a lone character followed by silence measures the time-out window from both sides.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2,
      ST_HOLD
   } rx_state_e;

   // Total bits in one frame: start + data + parity + stop(s).
   function automatic logic [3:0] frame_bits(input logic [1:0] dsel,
                                             input logic       par_en,
                                             input logic       two_stop);
      return 4'd7 + {2'b00, dsel} + {3'b000, par_en} + {3'b000, two_stop};
   endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else if (STAGES == 1) sr <= d;
            else sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sio_rx_deser.sv
module sio_rx_deser
   import sio_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] dsel,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       two_stop,
   output logic       done,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr,
   output logic       brk
);
   localparam int TW = $clog2(OSR);
   localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
   localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);

   rx_state_e     state;
   logic [TW-1:0] tcnt;
   logic [2:0]    bidx;
   logic [7:0]    shreg;
   logic          any_one;
   logic          par_acc;
   logic          par_bad;
   logic          stop_bad;
   logic [2:0]    last_idx;
   logic [2:0]    shamt;
   logic          centre;

   assign last_idx = 3'd4 + {1'b0, dsel};
   assign shamt    = 3'd3 - {1'b0, dsel};
   assign centre   = tick && (tcnt == T_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tcnt     <= '0;
         bidx     <= '0;
         shreg    <= '0;
         any_one  <= 1'b0;
         par_acc  <= 1'b0;
         par_bad  <= 1'b0;
         stop_bad <= 1'b0;
         done     <= 1'b0;
         data     <= '0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         brk      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick && state != ST_IDLE && state != ST_HOLD && !centre)
            tcnt <= tcnt + 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (tick && !rx) begin
                  state <= ST_START;
                  tcnt  <= '0;
               end
            end
            ST_START: begin
               if (tick && tcnt == T_HALF) begin
                  tcnt <= '0;
                  if (!rx) begin
                     state    <= ST_DATA;
                     bidx     <= '0;
                     any_one  <= 1'b0;
                     par_acc  <= 1'b0;
                     par_bad  <= 1'b0;
                     stop_bad <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_DATA: begin
               if (centre) begin
                  tcnt    <= '0;
                  shreg   <= {rx, shreg[7:1]};
                  any_one <= any_one | rx;
                  par_acc <= par_acc ^ rx;
                  bidx    <= bidx + 1'b1;
                  if (bidx == last_idx) state <= par_en ? ST_PAR : ST_STOP1;
               end
            end
            ST_PAR: begin
               if (centre) begin
                  tcnt    <= '0;
                  par_bad <= par_acc ^ rx ^ par_odd;
                  any_one <= any_one | rx;
                  state   <= ST_STOP1;
               end
            end
            ST_STOP1: begin
               if (centre) begin
                  tcnt <= '0;
                  if (!rx && !any_one) begin
                     done  <= 1'b1;
                     brk   <= 1'b1;
                     perr  <= 1'b0;
                     ferr  <= 1'b0;
                     state <= ST_HOLD;
                  end else if (two_stop) begin
                     stop_bad <= !rx;
                     state    <= ST_STOP2;
                  end else begin
                     done  <= 1'b1;
                     brk   <= 1'b0;
                     data  <= shreg >> shamt;
                     perr  <= par_en & par_bad;
                     ferr  <= !rx;
                     state <= rx ? ST_IDLE : ST_HOLD;
                  end
               end
            end
            ST_STOP2: begin
               if (centre) begin
                  tcnt  <= '0;
                  done  <= 1'b1;
                  brk   <= 1'b0;
                  data  <= shreg >> shamt;
                  perr  <= par_en & par_bad;
                  ferr  <= stop_bad | !rx;
                  state <= rx ? ST_IDLE : ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (tick && rx) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           wdata,
   input  logic                       pop,
   output logic [WIDTH-1:0]           rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rptr;
   logic             do_push;
   logic             do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/sio_rx_flow.sv
module sio_rx_flow #(
   parameter int DEPTH     = 64,
   parameter int RTS_LEVEL = 32,
   parameter int OSR       = 16,
   parameter int TO_WORDS  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       new_char,
   input  logic [$clog2(DEPTH+1)-1:0] count,
   input  logic [3:0]                 fbits,
   input  logic                       afc_en,
   output logic                       rts_n,
   output logic                       timeout
);
   localparam int CW      = $clog2(DEPTH + 1);
   localparam int LIM_MAX = 12 * OSR * TO_WORDS;
   localparam int LW      = $clog2(LIM_MAX + 1);

   logic [LW-1:0] limit;
   logic [LW-1:0] idle_cnt;
   logic [CW-1:0] free;
   logic          rts_q;
   logic          is_empty;

   assign limit    = LW'(fbits) * LW'(OSR * TO_WORDS);
   assign free     = CW'(DEPTH) - count;
   assign is_empty = (count == '0);
   assign rts_n    = afc_en ? rts_q : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         timeout  <= 1'b0;
      end else if (is_empty || new_char) begin
         idle_cnt <= '0;
         timeout  <= 1'b0;
      end else if (tick && !timeout) begin
         if (idle_cnt == limit - 1'b1) timeout <= 1'b1;
         else idle_cnt <= idle_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rts_q <= 1'b0;
      else if (free > CW'(RTS_LEVEL))  rts_q <= 1'b0;
      else if (free < CW'(RTS_LEVEL))  rts_q <= 1'b1;
   end
endmodule

// File: rtl/sio_rx_core.sv
module sio_rx_core
   import sio_rx_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int RTS_LEVEL   = 32,
   parameter int OSR         = 16,
   parameter int TO_WORDS    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick16,
   input  logic                       rxd,
   input  logic [1:0]                 fmt_dsel,
   input  logic                       fmt_par_en,
   input  logic                       fmt_par_odd,
   input  logic                       fmt_two_stop,
   input  logic                       afc_en,
   input  logic                       rd_en,
   output logic [7:0]                 rd_data,
   output logic                       rx_empty,
   output logic [$clog2(DEPTH+1)-1:0] rx_count,
   input  logic                       err_rd,
   output logic                       err_overrun,
   output logic                       err_parity,
   output logic                       err_frame,
   output logic                       err_break,
   output logic                       rx_timeout,
   output logic                       rts_n
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (RTS_LEVEL < 1 || RTS_LEVEL >= DEPTH) begin : g_bad_level
         $error("RTS_LEVEL must lie inside the store depth");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (TO_WORDS < 1) begin : g_bad_words
         $error("TO_WORDS must be at least 1");
      end
   endgenerate

   logic       rx_s;
   logic       f_done;
   logic [7:0] f_data;
   logic       f_perr;
   logic       f_ferr;
   logic       f_brk;
   logic       full;
   logic       push_ok;
   logic       lost;

   sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
   );

   sio_rx_deser #(.OSR(OSR)) u_deser (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .dsel(fmt_dsel), .par_en(fmt_par_en), .par_odd(fmt_par_odd),
      .two_stop(fmt_two_stop), .done(f_done), .data(f_data),
      .perr(f_perr), .ferr(f_ferr), .brk(f_brk)
   );

   assign push_ok = f_done && !f_brk && !full;
   assign lost    = f_done && !f_brk && full;

   sio_rx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_ok), .wdata(f_data),
      .pop(rd_en), .rdata(rd_data), .count(rx_count),
      .full(full), .empty(rx_empty)
   );

   sio_rx_flow #(.DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL), .OSR(OSR),
                 .TO_WORDS(TO_WORDS)) u_flow (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .new_char(push_ok),
      .count(rx_count),
      .fbits(frame_bits(fmt_dsel, fmt_par_en, fmt_two_stop)),
      .afc_en(afc_en), .rts_n(rts_n), .timeout(rx_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_overrun <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_break   <= 1'b0;
      end else begin
         err_overrun <= lost                      | (err_overrun & ~err_rd);
         err_parity  <= (f_done & !f_brk & f_perr) | (err_parity  & ~err_rd);
         err_frame   <= (f_done & !f_brk & f_ferr) | (err_frame   & ~err_rd);
         err_break   <= (f_done & f_brk)           | (err_break   & ~err_rd);
      end
   end
endmodule

// File: rtl/sio_rx_core_chk.sv
module sio_rx_core_chk #(
   parameter int DEPTH     = 64,
   parameter int RTS_LEVEL = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       afc_en,
   input logic                       err_rd,
   input logic [$clog2(DEPTH+1)-1:0] rx_count,
   input logic                       rx_empty,
   input logic                       rx_timeout,
   input logic                       rts_n,
   input logic                       err_parity,
   input logic                       err_overrun,
   input logic                       err_break,
   input logic                       push_ok
);
   int free_now;
   assign free_now = DEPTH - int'(rx_count);

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rx_count) <= DEPTH); // R2
   AST_RTS_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (afc_en && free_now < RTS_LEVEL) |=> (rts_n || !afc_en)); // R10
   AST_RTS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (afc_en && free_now > RTS_LEVEL) |=> (!rts_n || !afc_en)); // R10
   AST_BREAK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_break) |-> !$past(push_ok)); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && !err_rd) |=> err_parity); // R8
   AST_TIMEOUT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |=> !rx_timeout); // R9
   AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> int'($past(rx_count)) == DEPTH); // R7
endmodule

bind sio_rx_core sio_rx_core_chk #(.DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .err_rd(err_rd),
   .rx_count(rx_count), .rx_empty(rx_empty), .rx_timeout(rx_timeout),
   .rts_n(rts_n), .err_parity(err_parity), .err_overrun(err_overrun),
   .err_break(err_break), .push_ok(push_ok)
);

// File: tb/sio_rx_core_tb.sv
module sio_rx_core_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int BITCLK     = 16 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] fmt_dsel = 2'd3;
   logic       fmt_par_en = 1'b0;
   logic       fmt_par_odd = 1'b0;
   logic       fmt_two_stop = 1'b0;
   logic       afc_en = 1'b1;
   logic       rd_en = 1'b0;
   logic       err_rd = 1'b0;
   logic [7:0] rd_data;
   logic       rx_empty;
   logic [6:0] rx_count;
   logic       err_overrun, err_parity, err_frame, err_break;
   logic       rx_timeout, rts_n;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int tdiv = 0;

   sio_rx_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .fmt_dsel(fmt_dsel), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
      .fmt_two_stop(fmt_two_stop), .afc_en(afc_en), .rd_en(rd_en),
      .rd_data(rd_data), .rx_empty(rx_empty), .rx_count(rx_count),
      .err_rd(err_rd), .err_overrun(err_overrun), .err_parity(err_parity),
      .err_frame(err_frame), .err_break(err_break), .rx_timeout(rx_timeout),
      .rts_n(rts_n)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick16 <= (tdiv == TICK_DIV - 1);
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=%0d exp=<190000 cycles", cyc);
         report();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_bits(input int n);
      @(negedge clk) rxd = 1'b1;
      repeat (n * BITCLK) @(negedge clk);
   endtask

   task automatic put_bit(input logic v);
      @(negedge clk) rxd = v;
      repeat (BITCLK - 1) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit bad_par,
                             input logic stop1, input logic stop2);
      logic p;
      p = 1'b0;
      put_bit(1'b0);
      for (int i = 0; i < nb; i++) begin
         put_bit(d[i]);
         p = p ^ d[i];
      end
      if (fmt_par_en) put_bit(p ^ fmt_par_odd ^ bad_par);
      put_bit(stop1);
      if (fmt_two_stop) put_bit(stop2);
      @(negedge clk) rxd = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic pop_expect(input logic [7:0] exp, input string tag);
      @(negedge clk);
      chk(!rx_empty, {tag, " not empty"}, int'(rx_empty), 0);
      chk(rd_data == exp, {tag, " data"}, int'(rd_data), int'(exp));
      rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk) err_rd = 1'b1;
      @(negedge clk) err_rd = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(rx_empty && rx_count == 0, "R11 empty", int'(rx_count), 0);
      chk({err_overrun, err_parity, err_frame, err_break} == 4'b0, "R11 flags",
          int'({err_overrun, err_parity, err_frame, err_break}), 0);
      chk(!rx_timeout, "R11 timeout", int'(rx_timeout), 0);
      chk(!rts_n, "R11 rts_n", int'(rts_n), 0);
   endtask

   task automatic t_formats();
      send_frame(8'hA5, 8, 0, 1'b1, 1'b1);
      pop_expect(8'hA5, "R1 8N1");
      fmt_dsel = 2'd0;
      send_frame(8'h13, 5, 0, 1'b1, 1'b1);
      pop_expect(8'h13, "R1 5-bit");
      fmt_dsel = 2'd2;
      send_frame(8'h5A, 7, 0, 1'b1, 1'b1);
      pop_expect(8'h5A, "R1 7-bit");
      fmt_dsel = 2'd3;
      send_frame(8'h01, 8, 0, 1'b1, 1'b1);
      send_frame(8'h80, 8, 0, 1'b1, 1'b1);
      send_frame(8'hC3, 8, 0, 1'b1, 1'b1);
      @(negedge clk) chk(rx_count == 3, "R2 count", int'(rx_count), 3);
      pop_expect(8'h01, "R2 order0");
      pop_expect(8'h80, "R2 order1");
      pop_expect(8'hC3, "R2 order2");
      @(negedge clk) chk(rx_empty, "R2 drained", int'(rx_empty), 1);
   endtask

   task automatic t_glitch();
      @(negedge clk) rxd = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rxd = 1'b1;
      idle_bits(12);
      chk(rx_empty, "R3 glitch stored nothing", int'(rx_count), 0);
      chk({err_parity, err_frame, err_break} == 3'b0, "R3 no flags",
          int'({err_parity, err_frame, err_break}), 0);
   endtask

   task automatic t_parity();
      fmt_par_en = 1'b1; fmt_par_odd = 1'b0;
      send_frame(8'h96, 8, 0, 1'b1, 1'b1);
      @(negedge clk) chk(!err_parity, "R4 even good", int'(err_parity), 0);
      pop_expect(8'h96, "R4 even good");
      send_frame(8'h96, 8, 1, 1'b1, 1'b1);
      @(negedge clk) chk(err_parity, "R4 even bad", int'(err_parity), 1);
      pop_expect(8'h96, "R4 bad still stored");
      clear_flags();
      fmt_par_odd = 1'b1; fmt_dsel = 2'd2;
      send_frame(8'h07, 7, 0, 1'b1, 1'b1);
      @(negedge clk) chk(!err_parity, "R4 odd good", int'(err_parity), 0);
      pop_expect(8'h07, "R4 odd good");
      send_frame(8'h07, 7, 1, 1'b1, 1'b1);
      @(negedge clk) chk(err_parity, "R4 odd bad", int'(err_parity), 1);
      pop_expect(8'h07, "R4 odd bad stored");
      fmt_par_en = 1'b0; fmt_par_odd = 1'b0; fmt_dsel = 2'd3;
      @(negedge clk) chk(err_parity, "R8 parity sticky", int'(err_parity), 1);
      clear_flags();
      @(negedge clk) chk(!err_parity, "R8 parity cleared", int'(err_parity), 0);
   endtask

   task automatic t_frame();
      send_frame(8'h55, 8, 0, 1'b0, 1'b1);
      idle_bits(1);
      chk(err_frame, "R5 stop low", int'(err_frame), 1);
      chk(!err_break, "R5 not break", int'(err_break), 0);
      pop_expect(8'h55, "R5 stored");
      clear_flags();
      fmt_two_stop = 1'b1;
      send_frame(8'h81, 8, 0, 1'b1, 1'b1);
      @(negedge clk) chk(!err_frame, "R5 two stop good", int'(err_frame), 0);
      pop_expect(8'h81, "R5 two stop good");
      send_frame(8'h81, 8, 0, 1'b1, 1'b0);
      idle_bits(1);
      chk(err_frame, "R5 second stop low", int'(err_frame), 1);
      pop_expect(8'h81, "R5 second stop stored");
      fmt_two_stop = 1'b0;
      clear_flags();
      @(negedge clk) chk(!err_frame, "R8 frame cleared", int'(err_frame), 0);
   endtask

   task automatic t_break();
      @(negedge clk) rxd = 1'b0;
      repeat (12 * BITCLK) @(negedge clk);
      idle_bits(2);
      chk(err_break, "R6 break flag", int'(err_break), 1);
      chk(!err_frame, "R6 no frame flag", int'(err_frame), 0);
      chk(rx_empty, "R6 nothing stored", int'(rx_count), 0);
      clear_flags();
      @(negedge clk) chk(!err_break, "R8 break cleared", int'(err_break), 0);
      send_frame(8'h3C, 8, 0, 1'b1, 1'b1);
      pop_expect(8'h3C, "R6 recovers");
   endtask

   task automatic t_fill();
      for (int i = 0; i < 64; i++) begin
         send_frame(8'(i + 8'h10), 8, 0, 1'b1, 1'b1);
         if (i == 30) begin
            @(negedge clk) chk(!rts_n, "R10 free 33", int'(rts_n), 0);
         end
         if (i == 31) begin
            @(negedge clk) chk(!rts_n, "R10 free 32 hold low", int'(rts_n), 0);
         end
         if (i == 32) begin
            @(negedge clk) chk(rts_n, "R10 free 31", int'(rts_n), 1);
         end
      end
      @(negedge clk);
      chk(rx_count == 64 && !err_overrun, "R7 full no overrun", int'(rx_count), 64);
      send_frame(8'hEE, 8, 0, 1'b1, 1'b1);
      @(negedge clk);
      chk(err_overrun, "R7 overrun flag", int'(err_overrun), 1);
      chk(rx_count == 64, "R7 count kept", int'(rx_count), 64);
      for (int i = 0; i < 64; i++) begin
         pop_expect(8'(i + 8'h10), "R7 R2 contents");
         if (i == 31) begin
            @(negedge clk) chk(rts_n, "R10 free 32 hold high", int'(rts_n), 1);
         end
         if (i == 32) begin
            @(negedge clk) chk(!rts_n, "R10 free 33 again", int'(rts_n), 0);
         end
      end
      @(negedge clk) chk(rx_empty, "R7 drained", int'(rx_count), 0);
      clear_flags();
   endtask

   task automatic t_timeout();
      send_frame(8'h42, 8, 0, 1'b1, 1'b1);
      repeat (1800) @(negedge clk);
      chk(!rx_timeout, "R9 before 3 words", int'(rx_timeout), 0);
      repeat (150) @(negedge clk);
      chk(rx_timeout, "R9 after 3 words", int'(rx_timeout), 1);
      pop_expect(8'h42, "R9 data");
      repeat (2) @(negedge clk);
      chk(!rx_timeout, "R9 cleared on empty", int'(rx_timeout), 0);
   endtask

   task automatic t_afc_off();
      @(negedge clk) afc_en = 1'b0;
      @(negedge clk) chk(rts_n, "R10 afc off", int'(rts_n), 1);
      afc_en = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      idle_bits(2);
      t_formats();
      t_glitch();
      t_parity();
      t_frame();
      t_break();
      t_timeout();
      t_fill();
      t_afc_off();
      report();
   end
endmodule